// File: doc/BRIEF.md
# Integer Add/Subtract and Logic Unit with Status Flags

This block is a purely combinational integer unit. It takes two operands, an operation code and a width code. It returns a result word together with six status flags: carry, overflow, zero, sign, parity and auxiliary (nibble) carry. The operation can be addition, subtraction, bitwise AND, OR or XOR, or one of two flag-only forms. The flag-only forms are a compare, which subtracts, and a test, which ANDs. For these two forms the block drops the result and lowers the write-enable.

The active width is 8, 16 or 32 bits. Operand bits above that width are masked away before any arithmetic. Carry and the sign-related flags are taken at the most significant bit of the active width. The parity flag always looks at the lowest byte. A datapath places the unit between its operand sources and its register write port. It uses the write-enable to decide whether the result is stored, and it always latches the flags.

Top module: `flagged_alu`

## Requirements
- R1: The operation code selects the result: 0 = add, 1 = subtract (a − b), 2 = AND, 3 = OR, 4 = XOR, and 7 is decoded as add. For these codes the write-enable is 1 and the result is the width-masked value.
- R2: Code 5 (compare) sets every flag exactly as subtract would, and code 6 (test) sets every flag exactly as AND would. For both codes the write-enable is 0 and the result output reads 0.
- R3: Width code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Operand bits above the selected width have no effect on any output, and result bits above that width are 0.
- R4: Carry is set when an add carries out of the top bit of the selected width. It is also set when a subtract or compare needs a borrow, that is, when the unsigned masked a is less than the masked b.
- R5: Overflow is set when the signed (two's complement, at the selected width) sum or difference lies outside the representable range, and is clear otherwise.
- R6: Zero is set exactly when the width-masked operation value is all zeros. For compare and test, the operation value is the difference or the AND.
- R7: Sign equals the top bit of the width-masked operation value for every operation.
- R8: Parity is set when bits 7..0 of the operation value contain an even number of ones, at every width.
- R9: Auxiliary carry is set on an add when the sum of the low nibbles of the operands exceeds 15. On a subtract or compare it is set when the low nibble of a is less than the low nibble of b.
- R10: AND, OR, XOR and test force carry, overflow and auxiliary carry to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand (minuend for subtract) |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code |
| wsel_i | input | 2 | Active width code |
| res_o | output | 32 | Result, zero above active width |
| wr_en_o | output | 1 | Result should be written |
| cf_o | output | 1 | Carry / borrow |
| of_o | output | 1 | Signed overflow |
| zf_o | output | 1 | Zero |
| sf_o | output | 1 | Sign |
| pf_o | output | 1 | Even parity of low byte |
| af_o | output | 1 | Nibble carry / borrow |

## Verification
The interesting coincidence is a carry out of the top bit arriving together with signed overflow and a zero result. At 8 bits, 0x80 + 0x80 sets all three, while 0xFF + 0x01 sets carry, zero and auxiliary carry but not overflow. The bench provokes every such pairing by sweeping all 8-bit operand pairs under all eight operation codes, with random junk placed above the active width. It then repeats this for width corner values and random operands at 16 and 32 bits. Each flag is judged on its own against unsigned and signed arithmetic done in wide integers in the bench, so a wrong flag in a cycle where another flag is also set is reported individually.

// File: rtl/aluf_pkg.sv
package aluf_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_CMP  = 3'd5,
    OP_TST  = 3'd6,
    OP_ADDX = 3'd7
  } aluf_op_e;

  localparam int NLANE = 3;

  function automatic logic op_is_sub(input logic [2:0] op);
    return (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic logic op_is_logic(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TST);
  endfunction

  function automatic logic op_drops_result(input logic [2:0] op);
    return (op == OP_CMP) || (op == OP_TST);
  endfunction

endpackage

// File: rtl/aluf_width.sv
module aluf_width
  import aluf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        wsel_i,
  output logic [NLANE-1:0]  lane_oh_o,
  output logic [DATA_W-1:0] mask_o
);

  logic [DATA_W-1:0] lane_mask [NLANE];

  always_comb begin
    unique case (wsel_i)
      2'd0:    lane_oh_o = 3'b001;
      2'd1:    lane_oh_o = 3'b010;
      default: lane_oh_o = 3'b100;
    endcase
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = DATA_W >> (NLANE - 1 - i);
    assign lane_mask[i] = {DATA_W{1'b1}} >> (DATA_W - LW);
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (lane_oh_o[i]) mask_o = mask_o | lane_mask[i];
    end
  end

  always_comb begin
    if (!$isunknown(wsel_i)) begin
      p_one_lane_r3: assert ($onehot(lane_oh_o))
        else $error("lane select not one-hot");
    end
  end

endmodule

// File: rtl/aluf_addsub.sv
module aluf_addsub
  import aluf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [NLANE-1:0]  lane_oh_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              af_o
);

  localparam int EW = DATA_W + 1;

  logic [DATA_W-1:0] b_x;
  logic [EW-1:0]     ext;
  logic [NLANE-1:0]  lane_c, lane_v;
  logic              c_sel;

  assign b_x   = sub_i ? (~b_i & mask_i) : b_i;
  assign ext   = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o = ext[DATA_W-1:0] & mask_i;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = DATA_W >> (NLANE - 1 - i);
    assign lane_c[i] = ext[LW];
    assign lane_v[i] = (a_i[LW-1] == b_x[LW-1]) && (ext[LW-1] != a_i[LW-1]);
  end

  assign c_sel = |(lane_c & lane_oh_i);
  assign cf_o  = c_sel ^ sub_i;
  assign of_o  = |(lane_v & lane_oh_i);
  assign af_o  = (a_i[4] ^ b_x[4] ^ ext[4]) ^ sub_i;

  always_comb begin
    if (!$isunknown({a_i, b_i, mask_i, sub_i})) begin
      if (!sub_i) begin
        p_add_carry_r4: assert (cf_o == (({1'b0, a_i} + {1'b0, b_i}) > {1'b0, mask_i}))
          else $error("add carry mismatch");
        p_add_nibble_r9: assert (af_o == (({1'b0, a_i[3:0]} + {1'b0, b_i[3:0]}) > 5'd15))
          else $error("add nibble carry mismatch");
      end else begin
        p_sub_borrow_r4: assert (cf_o == (a_i < b_i))
          else $error("subtract borrow mismatch");
        p_sub_nibble_r9: assert (af_o == (a_i[3:0] < b_i[3:0]))
          else $error("subtract nibble borrow mismatch");
      end
    end
  end

endmodule

// File: rtl/aluf_logic.sv
module aluf_logic
  import aluf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] val_o
);

  always_comb begin
    unique case (op_i)
      OP_OR:   val_o = a_i | b_i;
      OP_XOR:  val_o = a_i ^ b_i;
      default: val_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/aluf_flaggen.sv
module aluf_flaggen
  import aluf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [NLANE-1:0]  lane_oh_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);

  logic [NLANE-1:0] lane_s;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = DATA_W >> (NLANE - 1 - i);
    assign lane_s[i] = val_i[LW-1];
  end

  assign zf_o = ~|val_i;
  assign sf_o = |(lane_s & lane_oh_i);
  assign pf_o = ~^val_i[7:0];

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
  import aluf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        wsel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o,
  output logic              af_o
);

  logic [NLANE-1:0]  lane_oh;
  logic [DATA_W-1:0] mask, a_m, b_m, as_val, lo_val, op_val;
  logic              is_sub, is_log;
  logic              as_cf, as_of, as_af;

  assign is_sub = op_is_sub(op_i);
  assign is_log = op_is_logic(op_i);

  aluf_width #(.DATA_W(DATA_W)) u_width (
    .wsel_i    (wsel_i),
    .lane_oh_o (lane_oh),
    .mask_o    (mask)
  );

  assign a_m = a_i & mask;
  assign b_m = b_i & mask;

  aluf_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i       (a_m),
    .b_i       (b_m),
    .mask_i    (mask),
    .lane_oh_i (lane_oh),
    .sub_i     (is_sub),
    .sum_o     (as_val),
    .cf_o      (as_cf),
    .of_o      (as_of),
    .af_o      (as_af)
  );

  aluf_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_m),
    .b_i   (b_m),
    .op_i  (op_i),
    .val_o (lo_val)
  );

  assign op_val = is_log ? lo_val : as_val;

  aluf_flaggen #(.DATA_W(DATA_W)) u_flags (
    .val_i     (op_val),
    .lane_oh_i (lane_oh),
    .zf_o      (zf_o),
    .sf_o      (sf_o),
    .pf_o      (pf_o)
  );

  assign cf_o    = is_log ? 1'b0 : as_cf;
  assign of_o    = is_log ? 1'b0 : as_of;
  assign af_o    = is_log ? 1'b0 : as_af;
  assign wr_en_o = ~op_drops_result(op_i);
  assign res_o   = wr_en_o ? op_val : '0;

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i, wsel_i})) begin
      if (op_i == OP_CMP || op_i == OP_TST) begin
        p_no_write_r2: assert (!wr_en_o && res_o == '0)
          else $error("flag-only op produced a result");
      end
      p_upper_zero_r3: assert ((res_o & ~mask) == '0)
        else $error("result bits above width not zero");
      if (is_log) begin
        p_logic_flags_r10: assert (!cf_o && !of_o && !af_o)
          else $error("logical op set an arithmetic flag");
      end
      if (wr_en_o && zf_o) begin
        p_zero_res_r6: assert (res_o == '0)
          else $error("zero flag with nonzero result");
      end
    end
  end

endmodule

// File: tb/flagged_alu_tb.sv
module flagged_alu_tb;

  logic        clk;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic [1:0]  wsel;
  logic [31:0] res;
  logic        wr_en, cf, of, zf, sf, pf, af;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  flagged_alu u_dut (
    .a_i(a), .b_i(b), .op_i(op), .wsel_i(wsel),
    .res_o(res), .wr_en_o(wr_en), .cf_o(cf), .of_o(of),
    .zf_o(zf), .sf_o(sf), .pf_o(pf), .af_o(af)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d wsel=%0d a=%h b=%h act=%h exp=%h",
               tag, what, op, wsel, a, b, act, exp);
    end
  endtask

  function automatic longint sgn(input longint v, input int w);
    return (v >= (64'sd1 <<< (w - 1))) ? v - (64'sd1 <<< w) : v;
  endfunction

  task automatic run_vec(input logic [31:0] ai, input logic [31:0] bi,
                         input logic [2:0] opi, input logic [1:0] wi);
    int     w;
    longint msk, am, bm, full, r, sr, lo, hi;
    logic   ecf, eof, eaf, ezf, esf, epf, ewr;
    string  rtag;
    a = ai; b = bi; op = opi; wsel = wi;
    #2;
    w   = (wi == 2'd0) ? 8 : (wi == 2'd1) ? 16 : 32;
    msk = (64'sd1 <<< w) - 1;
    am  = longint'(ai) & msk;
    bm  = longint'(bi) & msk;
    hi  = (64'sd1 <<< (w - 1)) - 1;
    lo  = -(64'sd1 <<< (w - 1));
    ecf = 0; eof = 0; eaf = 0;
    case (opi)
      3'd0, 3'd7: begin
        full = am + bm; r = full & msk; ecf = full > msk;
        sr = sgn(am, w) + sgn(bm, w); eof = (sr > hi) || (sr < lo);
        eaf = ((am & 15) + (bm & 15)) > 15;
      end
      3'd1, 3'd5: begin
        full = am - bm; r = full & msk; ecf = am < bm;
        sr = sgn(am, w) - sgn(bm, w); eof = (sr > hi) || (sr < lo);
        eaf = (am & 15) < (bm & 15);
      end
      3'd3:    r = am | bm;
      3'd4:    r = am ^ bm;
      default: r = am & bm;
    endcase
    ezf  = (r == 0);
    esf  = r[w-1];
    epf  = ~^r[7:0];
    ewr  = !(opi == 3'd5 || opi == 3'd6);
    rtag = ewr ? "R1" : "R2";
    chk(rtag, "result", res, ewr ? 32'(r) : 32'd0);
    chk(rtag, "wr_en", {31'd0, wr_en}, {31'd0, ewr});
    chk("R3", "upper", res & ~32'(msk), 32'd0);
    chk((opi == 3'd2 || opi == 3'd3 || opi == 3'd4 || opi == 3'd6) ? "R10" : "R4",
        "cf", {31'd0, cf}, {31'd0, ecf});
    chk("R5", "of", {31'd0, of}, {31'd0, eof});
    chk("R6", "zf", {31'd0, zf}, {31'd0, ezf});
    chk("R7", "sf", {31'd0, sf}, {31'd0, esf});
    chk("R8", "pf", {31'd0, pf}, {31'd0, epf});
    chk("R9", "af", {31'd0, af}, {31'd0, eaf});
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] cv [9];
    a = '0; b = '0; op = '0; wsel = '0;
    @(negedge clk);
    // reset-state style check: all-zero inputs give zero result, ZF and PF set (R6, R8)
    run_vec(32'd0, 32'd0, 3'd0, 2'd0);
    // named corner cases
    run_vec(32'h0000_00FF, 32'h0000_0001, 3'd0, 2'd0); // R4 carry, R9 aux, R6 zero
    run_vec(32'h0000_0000, 32'h0000_0001, 3'd1, 2'd0); // R4 borrow, R7 sign
    run_vec(32'h0000_0080, 32'h0000_0080, 3'd0, 2'd0); // R5 overflow with R4 carry
    run_vec(32'hABCD_1234, 32'h5555_1234, 3'd5, 2'd1); // R2 compare equal, R3 upper ignored
    run_vec(32'hFFFF_FFFF, 32'h8000_0000, 3'd6, 2'd2); // R2 test, R10
    run_vec(32'h7FFF_FFFF, 32'h0000_0001, 3'd0, 2'd3); // R3 code 3 is 32 bits, R5
    // exhaustive 8-bit sweep, all codes, junk above width (R1..R10)
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          run_vec({$urandom} << 8 | 32'(x), {$urandom} << 8 | 32'(y), 3'(o), 2'd0);
    // corner values at each width
    for (int wi = 0; wi < 4; wi++) begin
      int w = (wi == 0) ? 8 : (wi == 1) ? 16 : 32;
      logic [31:0] m = 32'hFFFF_FFFF >> (32 - w);
      cv[0] = 0; cv[1] = 1; cv[2] = 2; cv[3] = 32'hF; cv[4] = 32'h10;
      cv[5] = m >> 1; cv[6] = (m >> 1) + 1; cv[7] = m; cv[8] = m - 1;
      for (int o = 0; o < 8; o++)
        for (int i = 0; i < 9; i++)
          for (int j = 0; j < 9; j++)
            run_vec(cv[i] | (32'hA5A5_A5A5 & ~m), cv[j] | (32'h5A5A_5A5A & ~m), 3'(o), 2'(wi));
    end
    // random operands at 16 and 32 bits
    for (int k = 0; k < 4000; k++)
      run_vec($urandom, $urandom, 3'($urandom_range(0, 7)), 2'($urandom_range(1, 3)));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule